// File: doc/BRIEF.md
# Display Duty Timing Generator

This block produces the scan timing for a passive-matrix row driver from a single oscillator clock. A frequency-select input can insert a divide-by-two stage ahead of everything else, which gives the internal base rate. Two column-driver clocks run at half the base rate. A row shift clock and a frame-start marker are derived from those column cycles, and an alternation signal reverses drive polarity on every frame.

Two select inputs choose the duty. The duty fixes both the number of rows in a frame and the length of a row in column-clock cycles. A new duty selection is held off until the current frame completes, so a frame is never cut short. In slave mode the block generates no timing of its own. The column clocks and frame-start are held low, and the row shift clock and alternation signal are passed straight through from a master. All outputs are plain levels, and there is no handshake.

Top module: `dtg_top`

## Requirements
- R1: The duty_sel code sets the rows per frame: 2'b00 gives 48 rows, 2'b01 gives 64, 2'b10 gives 96 and 2'b11 gives 128.
- R2: A row lasts 64, 48, 32 or 24 column-clock periods for 48, 64, 96 or 128 rows respectively. row_clk is high for the first half of the row and low for the second half, and it changes only where colclk_a falls.
- R3: colclk_a toggles once per base-clock period, so its period is two base periods. colclk_b is always the inverse of colclk_a in master mode.
- R4: With freq_sel low the base clock equals osc_clk. With freq_sel high the base clock is osc_clk divided by two, which doubles every period.
- R5: frame_start is high for exactly the first row of every frame and low for all other rows.
- R6: alt inverts at each frame boundary, at the same edge where frame_start rises, and at no other time.
- R7: A duty_sel change made during a frame leaves that frame's row count and row length unchanged. The change applies from the next frame onward.
- R8: While rst is high (synchronous, active high) the generator sits at row 0, column count 0, with alt low, frame_start high, row_clk high and colclk_a low.
- R9: With master_sel low, colclk_a, colclk_b and frame_start are held low. row_clk follows slv_shift_in and alt follows slv_alt_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock, which clocks all registers |
| rst | input | 1 | Synchronous reset, active high |
| freq_sel | input | 1 | 1 inserts a divide-by-two stage before the base clock |
| duty_sel | input | 2 | Duty code (see R1) |
| master_sel | input | 1 | 1 selects master mode, 0 selects slave mode |
| slv_shift_in | input | 1 | Row shift clock from a master, used in slave mode |
| slv_alt_in | input | 1 | Alternation signal from a master, used in slave mode |
| colclk_a | output | 1 | Column clock, phase A |
| colclk_b | output | 1 | Column clock, phase B (inverse of phase A) |
| row_clk | output | 1 | Row shift clock |
| frame_start | output | 1 | High during the first row of each frame |
| alt | output | 1 | Frame alternation signal |

## Verification
Several properties are checked on every cycle. colclk_a toggles on each cycle when no predivider is used. row_clk moves only where colclk_a falls. alt flips only together with a rising frame_start. Slave mode keeps the generated outputs quiet and forwards the inputs, and reset leaves the documented idle state. The bench scenarios are needed for the values that span whole rows and frames: the row count of each duty code, row length and high time, the doubling under freq_sel, and a duty change taking effect only after the frame in progress has finished.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int ROW_W = 8;
  localparam int PER_W = 7;

  typedef enum logic [1:0] {
    DUTY_48  = 2'b00,
    DUTY_64  = 2'b01,
    DUTY_96  = 2'b10,
    DUTY_128 = 2'b11
  } duty_e;

  function automatic logic [ROW_W-1:0] rows_of(input duty_e d);
    case (d)
      DUTY_48:  rows_of = ROW_W'(48);
      DUTY_64:  rows_of = ROW_W'(64);
      DUTY_96:  rows_of = ROW_W'(96);
      default:  rows_of = ROW_W'(128);
    endcase
  endfunction

  function automatic logic [PER_W-1:0] period_of(input duty_e d);
    case (d)
      DUTY_48:  period_of = PER_W'(64);
      DUTY_64:  period_of = PER_W'(48);
      DUTY_96:  period_of = PER_W'(32);
      default:  period_of = PER_W'(24);
    endcase
  endfunction
endpackage

// File: rtl/dtg_prediv.sv
module dtg_prediv (
  input  logic clk,
  input  logic rst,
  input  logic freq_sel,
  output logic base_tick
);
  logic half_q;

  always_ff @(posedge clk) begin
    if (rst) half_q <= 1'b0;
    else     half_q <= ~half_q;
  end

  assign base_tick = freq_sel ? half_q : 1'b1;
endmodule

// File: rtl/dtg_colclk.sv
module dtg_colclk (
  input  logic clk,
  input  logic rst,
  input  logic base_tick,
  output logic col_ph,
  output logic col_end
);
  logic ph_q;

  always_ff @(posedge clk) begin
    if (rst)            ph_q <= 1'b0;
    else if (base_tick) ph_q <= ~ph_q;
  end

  assign col_ph  = ph_q;
  assign col_end = base_tick & ph_q;
endmodule

// File: rtl/dtg_row_seq.sv
module dtg_row_seq
  import dtg_pkg::*;
#(
  parameter int ROWS_W = ROW_W,
  parameter int CNT_W  = PER_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       col_end,
  input  logic [1:0] duty_sel,
  output logic       row_level,
  output logic       frame_first,
  output logic       alt_q
);
  duty_e             act_q;
  logic [CNT_W-1:0]  col_cnt;
  logic [ROWS_W-1:0] row_cnt;
  logic [CNT_W-1:0]  per;
  logic [ROWS_W-1:0] rows;
  logic              row_last, col_last;

  always_comb begin
    per      = CNT_W'(period_of(act_q));
    rows     = ROWS_W'(rows_of(act_q));
    col_last = (col_cnt == per - CNT_W'(1));
    row_last = (row_cnt == rows - ROWS_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= duty_e'(duty_sel);
      col_cnt <= '0;
      row_cnt <= '0;
      alt_q   <= 1'b0;
    end else if (col_end) begin
      if (col_last) begin
        col_cnt <= '0;
        if (row_last) begin
          row_cnt <= '0;
          alt_q   <= ~alt_q;
          act_q   <= duty_e'(duty_sel);
        end else begin
          row_cnt <= row_cnt + ROWS_W'(1);
        end
      end else begin
        col_cnt <= col_cnt + CNT_W'(1);
      end
    end
  end

  assign row_level   = (col_cnt < (per >> 1));
  assign frame_first = (row_cnt == '0);
endmodule

// File: rtl/dtg_top.sv
module dtg_top (
  input  logic       osc_clk,
  input  logic       rst,
  input  logic       freq_sel,
  input  logic [1:0] duty_sel,
  input  logic       master_sel,
  input  logic       slv_shift_in,
  input  logic       slv_alt_in,
  output logic       colclk_a,
  output logic       colclk_b,
  output logic       row_clk,
  output logic       frame_start,
  output logic       alt
);
  logic base_tick, col_ph, col_end;
  logic row_level, frame_first, alt_q;

  dtg_prediv u_prediv (
    .clk(osc_clk), .rst(rst), .freq_sel(freq_sel), .base_tick(base_tick)
  );

  dtg_colclk u_colclk (
    .clk(osc_clk), .rst(rst), .base_tick(base_tick),
    .col_ph(col_ph), .col_end(col_end)
  );

  dtg_row_seq u_rows (
    .clk(osc_clk), .rst(rst), .col_end(col_end), .duty_sel(duty_sel),
    .row_level(row_level), .frame_first(frame_first), .alt_q(alt_q)
  );

  always_comb begin
    if (master_sel) begin
      colclk_a    = col_ph;
      colclk_b    = ~col_ph;
      row_clk     = row_level;
      frame_start = frame_first;
      alt         = alt_q;
    end else begin
      colclk_a    = 1'b0;
      colclk_b    = 1'b0;
      row_clk     = slv_shift_in;
      frame_start = 1'b0;
      alt         = slv_alt_in;
    end
  end
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker (
  input logic       osc_clk,
  input logic       rst,
  input logic       freq_sel,
  input logic       master_sel,
  input logic       slv_shift_in,
  input logic       slv_alt_in,
  input logic       colclk_a,
  input logic       colclk_b,
  input logic       row_clk,
  input logic       frame_start,
  input logic       alt
);
  // R3
  colclk_toggle_chk: assert property (@(posedge osc_clk) disable iff (rst)
    (master_sel && $past(master_sel) && !freq_sel && !$past(freq_sel) && !$past(rst))
      |-> (colclk_a != $past(colclk_a)));

  // R2
  row_edge_chk: assert property (@(posedge osc_clk) disable iff (rst)
    (master_sel && $past(master_sel) && !$past(rst) && !$stable(row_clk))
      |-> $fell(colclk_a));

  // R6
  alt_boundary_chk: assert property (@(posedge osc_clk) disable iff (rst)
    (master_sel && $past(master_sel) && !$past(rst) && !$stable(alt))
      |-> $rose(frame_start));

  // R9
  slave_quiet_chk: assert property (@(posedge osc_clk) disable iff (rst)
    !master_sel |-> (!colclk_a && !colclk_b && !frame_start));

  // R9
  slave_fwd_chk: assert property (@(posedge osc_clk) disable iff (rst)
    !master_sel |-> (row_clk == slv_shift_in && alt == slv_alt_in));

  // R8
  reset_state_chk: assert property (@(posedge osc_clk)
    (rst && master_sel) |=> (!master_sel || (!alt && frame_start && row_clk && !colclk_a)));
endmodule

bind dtg_top dtg_checker u_dtg_checker (
  .osc_clk(osc_clk), .rst(rst), .freq_sel(freq_sel), .master_sel(master_sel),
  .slv_shift_in(slv_shift_in), .slv_alt_in(slv_alt_in), .colclk_a(colclk_a),
  .colclk_b(colclk_b), .row_clk(row_clk), .frame_start(frame_start), .alt(alt)
);

// File: tb/test_dtg_top.sv
module test_dtg_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       freq_sel = 1'b0;
  logic [1:0] duty_sel = 2'b00;
  logic       master_sel = 1'b1;
  logic       slv_shift_in = 1'b0;
  logic       slv_alt_in = 1'b0;
  logic       colclk_a, colclk_b, row_clk, frame_start, alt;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dtg_top i_dtg_top (
    .osc_clk(clk), .rst(rst), .freq_sel(freq_sel), .duty_sel(duty_sel),
    .master_sel(master_sel), .slv_shift_in(slv_shift_in), .slv_alt_in(slv_alt_in),
    .colclk_a(colclk_a), .colclk_b(colclk_b), .row_clk(row_clk),
    .frame_start(frame_start), .alt(alt)
  );

  function automatic int exp_rows(input logic [1:0] d);
    case (d) 2'b00: return 48; 2'b01: return 64; 2'b10: return 96; default: return 128; endcase
  endfunction
  function automatic int exp_per(input logic [1:0] d);
    case (d) 2'b00: return 64; 2'b01: return 48; 2'b10: return 32; default: return 24; endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] d, input logic fs);
    @(negedge clk);
    master_sel = 1'b1; duty_sel = d; freq_sel = fs; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // frame measure: waits for a frame_start rise, counts to the next rise
  task automatic measure_frame(output int rows, output int cycles, output int fs_hi,
                               output logic a0, output logic a1);
    logic pf, pr;
    pf = frame_start;
    forever begin @(negedge clk); if (frame_start && !pf) break; pf = frame_start; end
    a0 = alt; rows = 1; cycles = 0; fs_hi = 1; pf = 1'b1; pr = row_clk;
    forever begin
      @(negedge clk);
      cycles++;
      if (frame_start && !pf) break;
      if (row_clk && !pr) rows++;
      if (frame_start) fs_hi++;
      pf = frame_start; pr = row_clk;
    end
    a1 = alt;
  endtask

  task automatic measure_row(output int hi, output int per);
    logic pr;
    pr = row_clk;
    forever begin @(negedge clk); if (row_clk && !pr) break; pr = row_clk; end
    hi = 1; per = 0; pr = 1'b1;
    forever begin
      @(negedge clk);
      per++;
      if (row_clk && !pr) break;
      if (row_clk) hi++;
      pr = row_clk;
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    master_sel = 1'b1; duty_sel = 2'b01; freq_sel = 1'b0; rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(alt == 1'b0, "R8 alt in reset", alt, 0);
    chk(frame_start == 1'b1, "R8 frame_start in reset", frame_start, 1);
    chk(row_clk == 1'b1, "R8 row_clk in reset", row_clk, 1);
    chk(colclk_a == 1'b0, "R8 colclk_a in reset", colclk_a, 0);
    rst = 1'b0;
  endtask

  task automatic t_duty(input logic [1:0] d, input logic fs);
    int rows, cyc, fsh, hi, per, m;
    logic a0, a1;
    m = fs ? 2 : 1;
    do_reset(d, fs);
    measure_frame(rows, cyc, fsh, a0, a1);
    chk(rows == exp_rows(d), "R1 rows per frame", rows, exp_rows(d));
    chk(cyc == exp_rows(d) * exp_per(d) * 2 * m, "R4 frame length in osc cycles", cyc,
        exp_rows(d) * exp_per(d) * 2 * m);
    chk(fsh == exp_per(d) * 2 * m, "R5 frame_start spans one row", fsh, exp_per(d) * 2 * m);
    chk(a1 != a0, "R6 alt inverts at frame boundary", a1, !a0);
    measure_row(hi, per);
    chk(per == exp_per(d) * 2 * m, "R2 row period", per, exp_per(d) * 2 * m);
    chk(hi == exp_per(d) * m, "R2 row_clk high half", hi, exp_per(d) * m);
  endtask

  task automatic t_colclk(input logic fs);
    logic pa;
    int run, bad;
    do_reset(2'b11, fs);
    @(negedge clk);
    pa = colclk_a; run = 1; bad = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (colclk_b != ~colclk_a) bad++;
      if (colclk_a == pa) run++;
      else begin
        if (i > 2 && run != (fs ? 2 : 1)) bad++;
        run = 1;
      end
      pa = colclk_a;
    end
    chk(bad == 0, fs ? "R4 colclk_a half-rate of divided base" : "R3 colclk_a toggles per cycle, b inverse",
        bad, 0);
  endtask

  task automatic t_duty_change(input logic [1:0] da, input logic [1:0] db);
    logic pr, pf;
    int rises, rows;
    do_reset(da, 1'b0);
    pr = row_clk; rises = 0;
    while (rises < 5) begin
      @(negedge clk);
      if (row_clk && !pr) rises++;
      pr = row_clk;
    end
    duty_sel = db;
    rises = 0; pf = frame_start;
    forever begin
      @(negedge clk);
      if (frame_start && !pf) break;
      if (row_clk && !pr) rises++;
      pr = row_clk; pf = frame_start;
    end
    chk(rises == exp_rows(da) - 6, "R7 current frame keeps old duty", rises, exp_rows(da) - 6);
    rows = 1; pf = 1'b1; pr = 1'b1;
    forever begin
      @(negedge clk);
      if (frame_start && !pf) break;
      if (row_clk && !pr) rows++;
      pr = row_clk; pf = frame_start;
    end
    chk(rows == exp_rows(db), "R7 next frame uses new duty", rows, exp_rows(db));
  endtask

  task automatic t_slave();
    do_reset(2'b00, 1'b0);
    @(negedge clk);
    master_sel = 1'b0;
    for (int p = 0; p < 4; p++) begin
      @(negedge clk);
      slv_shift_in = p[0]; slv_alt_in = p[1];
      repeat (3) begin
        @(negedge clk);
        chk(row_clk == p[0] && alt == p[1], "R9 slave forwards inputs",
            {row_clk, alt}, {p[0], p[1]});
        chk(!colclk_a && !colclk_b && !frame_start, "R9 slave outputs held low",
            {colclk_a, colclk_b, frame_start}, 0);
      end
    end
    master_sel = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_colclk(1'b0);
    t_colclk(1'b1);
    t_duty(2'b00, 1'b0);
    t_duty(2'b01, 1'b0);
    t_duty(2'b10, 1'b0);
    t_duty(2'b11, 1'b0);
    t_duty(2'b10, 1'b1);
    t_duty_change(2'b01, 2'b11);
    t_slave();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule